// File: doc/BRIEF.md
# Peripheral Clock Gate Register

This block holds the run/stop state of the clocks feeding sixteen peripherals, plus two small control registers for sleep behaviour. Each peripheral owns one bit of a 16-bit gate register. A bit at 1 stops that peripheral's clock and a bit at 0 lets it run. The block drives one registered clock-enable output per peripheral. A downstream clock-gating cell consumes these outputs directly.

Software can reach the gate register in three ways. A plain write replaces the whole register. A set strobe raises only the bits selected by a mask. A clear strobe lowers only the masked bits. With the strobes, two agents can update different bits without a read-modify-write race. The device-controller bit also tells the rest of the chip whether automatic suspend is armed.

A sleep-control register holds a device-controller clock-enable bit and a host-controller suspend bit. A low-power register chooses sleep over idle on a wait and also selects doze. Any of the three registers can be read back through a select input.

Top module: `clkgate_regs`

## Requirements
- R1: During and right after synchronous reset, the gate register reads 0, every `clk_enable` bit is 1, and the sleep-control and low-power registers read 0.
- R2: A plain write (`reg_wr`=1, `reg_sel`=0) loads `reg_wdata` into the gate register at the clock edge. `rd_sel`=0 then reads back the new value.
- R3: A set strobe (`gate_set`=1) drives each gate bit with a 1 in `gate_mask` to 1. All other bits keep their value.
- R4: A clear strobe (`gate_clr`=1) drives each gate bit with a 1 in `gate_mask` to 0. All other bits keep their value.
- R5: When several updates land in the same cycle, they apply in a fixed order: the plain write first, then the set strobe, then the clear strobe. Clear therefore wins on any bit that both strobes hit.
- R6: `clk_enable[i]` is the inverse of gate bit i and changes one clock after the gate register, only at a clock edge.
- R7: Peripheral positions are fixed, from bit 0 up: serial port 0, timer, real-time clock, I2C, SPI, audio interface, I2S, MMC, ADC, camera, LCD, device controller (bit 11), DMA, image unit, host controller, serial port 1. `auto_suspend` follows gate bit 11, so setting that bit arms automatic suspend and clearing it disarms it.
- R8: The sleep-control register (`reg_sel`=1) stores bit 6 as `dev_clk_on` and bit 7 as `host_suspend`. Every other bit reads 0.
- R9: The low-power register (`reg_sel`=2) stores bit 0 as `sleep_on_wait` (1 = sleep on wait, 0 = idle) and bit 2 as `doze_sel`. Every other bit reads 0.
- R10: A write to one register leaves the other registers unchanged. `reg_sel`=3 names no register: writes to it are ignored and `rd_sel`=3 reads 0. With no write and no strobe, the gate register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Plain write strobe |
| reg_sel | input | 2 | Write target: 0 gate, 1 sleep-control, 2 low-power, 3 none |
| reg_wdata | input | 16 | Plain write data |
| gate_set | input | 1 | Set-bits strobe on the gate register |
| gate_clr | input | 1 | Clear-bits strobe on the gate register |
| gate_mask | input | 16 | Bits affected by the set and clear strobes |
| rd_sel | input | 2 | Readback select, same encoding as `reg_sel` |
| rd_data | output | 16 | Readback value of the selected register |
| clk_enable | output | 16 | Registered per-peripheral clock enables (1 = run) |
| auto_suspend | output | 1 | Automatic suspend armed (gate bit 11) |
| dev_clk_on | output | 1 | Device-controller clock enable |
| host_suspend | output | 1 | Host-controller suspend |
| sleep_on_wait | output | 1 | Sleep selected on wait (0 = idle) |
| doze_sel | output | 1 | Doze mode selected |

## Verification
The bench goes after same-cycle collisions: plain write together with set, set together with clear on overlapping masks, and all three at once. A design with the wrong priority would leave a bit running that should be stopped, or the reverse. It checks that `clk_enable` trails the register by exactly one edge, so a combinational or doubly registered enable shows up as a mismatch. It also checks that writes to the unmapped select and to the neighbouring registers leave the gate state alone, and that reserved bits in the sleep and low-power registers always read 0. A decoder that is too wide would change peripheral clocks or leak stray bits.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    parameter int GATE_W = 16;
    parameter int REG_W  = 16;

    // Peripheral bit positions in the gate register (fixed assignment).
    localparam int BIT_UART0  = 0;
    localparam int BIT_TIMER  = 1;
    localparam int BIT_RTC    = 2;
    localparam int BIT_I2C    = 3;
    localparam int BIT_SPI    = 4;
    localparam int BIT_AUDIO  = 5;
    localparam int BIT_I2S    = 6;
    localparam int BIT_MMC    = 7;
    localparam int BIT_ADC    = 8;
    localparam int BIT_CAM    = 9;
    localparam int BIT_LCD    = 10;
    localparam int BIT_DEVCTL = 11;
    localparam int BIT_DMA    = 12;
    localparam int BIT_IMG    = 13;
    localparam int BIT_HOST   = 14;
    localparam int BIT_UART1  = 15;

    // Field positions in the sleep-control and low-power registers.
    localparam int SLP_DEV_EN_BIT    = 6;
    localparam int SLP_HOST_SUSP_BIT = 7;
    localparam int LP_SLEEP_BIT      = 0;
    localparam int LP_DOZE_BIT       = 2;

    typedef enum logic [1:0] {
        SEL_GATE  = 2'd0,
        SEL_SLEEP = 2'd1,
        SEL_LPWR  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic [GATE_W-1:0] wdata;
        logic              set;
        logic              clr;
        logic [GATE_W-1:0] mask;
    } gate_cmd_t;

    typedef struct packed {
        logic dev_clk_on;
        logic host_suspend;
    } sleep_ctl_t;

    typedef struct packed {
        logic sleep_on_wait;
        logic doze;
    } lpwr_ctl_t;

    // Update order: plain write, then set, then clear (clear wins).
    function automatic logic [GATE_W-1:0] gate_next(
        input logic [GATE_W-1:0] cur,
        input gate_cmd_t         cmd
    );
        logic [GATE_W-1:0] nx;
        nx = cmd.wr ? cmd.wdata : cur;
        if (cmd.set) nx = nx | cmd.mask;
        if (cmd.clr) nx = nx & ~cmd.mask;
        return nx;
    endfunction

    function automatic logic [REG_W-1:0] sleep_pack(input sleep_ctl_t s);
        logic [REG_W-1:0] v;
        v = '0;
        v[SLP_DEV_EN_BIT]    = s.dev_clk_on;
        v[SLP_HOST_SUSP_BIT] = s.host_suspend;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] lpwr_pack(input lpwr_ctl_t l);
        logic [REG_W-1:0] v;
        v = '0;
        v[LP_SLEEP_BIT] = l.sleep_on_wait;
        v[LP_DOZE_BIT]  = l.doze;
        return v;
    endfunction

endpackage

// File: rtl/clkgate_gate_reg.sv
module clkgate_gate_reg
    import clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  gate_cmd_t         cmd,
    output logic [GATE_W-1:0] gate_q
);

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= gate_next(gate_q, cmd);
    end

endmodule

// File: rtl/clkgate_ctl_regs.sv
module clkgate_ctl_regs
    import clkgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sleep,
    input  logic             wr_lpwr,
    input  logic [REG_W-1:0] wdata,
    output sleep_ctl_t       sleep_q,
    output lpwr_ctl_t        lpwr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q <= '0;
        end else if (wr_sleep) begin
            sleep_q.dev_clk_on   <= wdata[SLP_DEV_EN_BIT];
            sleep_q.host_suspend <= wdata[SLP_HOST_SUSP_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lpwr_q <= '0;
        end else if (wr_lpwr) begin
            lpwr_q.sleep_on_wait <= wdata[LP_SLEEP_BIT];
            lpwr_q.doze          <= wdata[LP_DOZE_BIT];
        end
    end

endmodule

// File: rtl/clkgate_out_stage.sv
module clkgate_out_stage
    import clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [GATE_W-1:0] gate_q,
    output logic [GATE_W-1:0] clk_enable
);

    for (genvar i = 0; i < GATE_W; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) clk_enable[i] <= 1'b1;
            else     clk_enable[i] <= ~gate_q[i];
        end
    end

endmodule

// File: rtl/clkgate_regs.sv
module clkgate_regs
    import clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              gate_set,
    input  logic              gate_clr,
    input  logic [GATE_W-1:0] gate_mask,
    input  logic [1:0]        rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic [GATE_W-1:0] clk_enable,
    output logic              auto_suspend,
    output logic              dev_clk_on,
    output logic              host_suspend,
    output logic              sleep_on_wait,
    output logic              doze_sel
);

    reg_sel_e          wsel;
    reg_sel_e          rsel;
    gate_cmd_t         cmd;
    logic [GATE_W-1:0] gate_q;
    sleep_ctl_t        sleep_q;
    lpwr_ctl_t         lpwr_q;

    assign wsel = reg_sel_e'(reg_sel);
    assign rsel = reg_sel_e'(rd_sel);

    always_comb begin
        cmd.wr    = reg_wr && (wsel == SEL_GATE);
        cmd.wdata = reg_wdata[GATE_W-1:0];
        cmd.set   = gate_set;
        cmd.clr   = gate_clr;
        cmd.mask  = gate_mask;
    end

    clkgate_gate_reg u_gate (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .gate_q (gate_q)
    );

    clkgate_ctl_regs u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_sleep (reg_wr && (wsel == SEL_SLEEP)),
        .wr_lpwr  (reg_wr && (wsel == SEL_LPWR)),
        .wdata    (reg_wdata),
        .sleep_q  (sleep_q),
        .lpwr_q   (lpwr_q)
    );

    clkgate_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .gate_q     (gate_q),
        .clk_enable (clk_enable)
    );

    always_comb begin
        unique case (rsel)
            SEL_GATE:  rd_data = REG_W'(gate_q);
            SEL_SLEEP: rd_data = sleep_pack(sleep_q);
            SEL_LPWR:  rd_data = lpwr_pack(lpwr_q);
            default:   rd_data = '0;
        endcase
    end

    assign auto_suspend  = gate_q[BIT_DEVCTL];
    assign dev_clk_on    = sleep_q.dev_clk_on;
    assign host_suspend  = sleep_q.host_suspend;
    assign sleep_on_wait = lpwr_q.sleep_on_wait;
    assign doze_sel      = lpwr_q.doze;

endmodule

// File: rtl/clkgate_regs_chk.sv
module clkgate_regs_chk
    import clkgate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic              gate_set,
    input logic              gate_clr,
    input logic [GATE_W-1:0] gate_mask,
    input logic [GATE_W-1:0] gate_q,
    input logic [GATE_W-1:0] clk_enable,
    input logic              auto_suspend
);

    logic gate_wr;
    assign gate_wr = reg_wr && (reg_sel == 2'd0);

    // R1: first cycle out of reset sees reset state
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gate_q == '0 && clk_enable == '1));

    // R3: set strobe without clear raises every masked bit
    p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (gate_set && !gate_clr) |=> ((gate_q & $past(gate_mask)) == $past(gate_mask)));

    // R4, R5: clear strobe always lowers masked bits
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        gate_clr |=> ((gate_q & $past(gate_mask)) == '0));

    // R6: enable trails the gate register by one edge
    p_enable_lag_r6: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> (clk_enable == ~$past(gate_q)));

    // R7: armed suspend stops the device-controller clock next cycle
    p_auto_suspend_r7: assert property (@(posedge clk) disable iff (rst)
        auto_suspend |=> !clk_enable[BIT_DEVCTL]);

    // R10: no update source means gate state holds
    p_gate_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!gate_wr && !gate_set && !gate_clr) |=> $stable(gate_q));

endmodule

bind clkgate_regs clkgate_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .gate_set     (gate_set),
    .gate_clr     (gate_clr),
    .gate_mask    (gate_mask),
    .gate_q       (gate_q),
    .clk_enable   (clk_enable),
    .auto_suspend (auto_suspend)
);

// File: tb/clkgate_regs_test.sv
module clkgate_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic        gate_set = 1'b0;
    logic        gate_clr = 1'b0;
    logic [15:0] gate_mask = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic [15:0] clk_enable;
    logic        auto_suspend, dev_clk_on, host_suspend, sleep_on_wait, doze_sel;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_gate = '0;
    logic [15:0] m_sleep = '0;
    logic [15:0] m_lpwr = '0;

    always #5 clk = ~clk;

    clkgate_regs uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .gate_set(gate_set), .gate_clr(gate_clr),
        .gate_mask(gate_mask), .rd_sel(rd_sel), .rd_data(rd_data),
        .clk_enable(clk_enable), .auto_suspend(auto_suspend),
        .dev_clk_on(dev_clk_on), .host_suspend(host_suspend),
        .sleep_on_wait(sleep_on_wait), .doze_sel(doze_sel)
    );

    function automatic logic [15:0] exp_gate(
        input logic [15:0] cur, input logic wr, input logic [15:0] wd,
        input logic st, input logic cl, input logic [15:0] mk);
        logic [15:0] n;
        n = wr ? wd : cur;
        if (st) n = n | mk;
        if (cl) n = n & ~mk;
        return n;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_all(input string req);
        rd_sel = 2'd0; #1; chk({req, " R2 gate readback"}, rd_data, m_gate);
        rd_sel = 2'd1; #1; chk({req, " R8 sleep readback"}, rd_data, m_sleep);
        rd_sel = 2'd2; #1; chk({req, " R9 lpwr readback"}, rd_data, m_lpwr);
        rd_sel = 2'd3; #1; chk({req, " R10 unmapped read"}, rd_data, 16'h0);
        chk({req, " R7 auto_suspend"}, {15'd0, auto_suspend}, {15'd0, m_gate[11]});
        chk({req, " R8 outputs"}, {14'd0, dev_clk_on, host_suspend}, {14'd0, m_sleep[6], m_sleep[7]});
        chk({req, " R9 outputs"}, {14'd0, sleep_on_wait, doze_sel}, {14'd0, m_lpwr[0], m_lpwr[2]});
    endtask

    // Drive one cycle of stimulus at a negedge, check at the next negedge.
    task automatic op(input string req, input logic wr, input logic [1:0] sel,
                      input logic [15:0] wd, input logic st, input logic cl,
                      input logic [15:0] mk);
        logic [15:0] prev;
        prev = m_gate;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        gate_set = st; gate_clr = cl; gate_mask = mk;
        m_gate = exp_gate(m_gate, wr && sel == 2'd0, wd, st, cl, mk);
        if (wr && sel == 2'd1) m_sleep = wd & 16'h00C0;
        if (wr && sel == 2'd2) m_lpwr  = wd & 16'h0005;
        @(negedge clk);
        reg_wr = 1'b0; gate_set = 1'b0; gate_clr = 1'b0;
        chk({req, " R6 enable lag"}, clk_enable, ~prev);
        read_all(req);
        @(negedge clk);
        chk({req, " R6 enable follow"}, clk_enable, ~m_gate);
    endtask

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset enables", clk_enable, 16'hFFFF);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 enables after reset", clk_enable, 16'hFFFF);
        read_all("R1");

        op("R2 plain write", 1, 2'd0, 16'hA5C3, 0, 0, 16'h0);
        op("R3 set", 0, 2'd0, 16'h0, 1, 0, 16'h0F0F);
        op("R4 clear", 0, 2'd0, 16'h0, 0, 1, 16'h00FF);
        op("R5 set+clear overlap", 0, 2'd0, 16'h0, 1, 1, 16'h3C3C);
        op("R5 write+set", 1, 2'd0, 16'h0001, 1, 0, 16'h8000);
        op("R5 write+set+clear", 1, 2'd0, 16'hFFFF, 1, 1, 16'h0F00);
        op("R7 arm suspend", 0, 2'd0, 16'h0, 1, 0, 16'h0800);
        op("R7 disarm suspend", 0, 2'd0, 16'h0, 0, 1, 16'h0800);
        op("R8 sleep write", 1, 2'd1, 16'hFFFF, 0, 0, 16'h0);
        op("R8 sleep partial", 1, 2'd1, 16'h0040, 0, 0, 16'h0);
        op("R9 lpwr write", 1, 2'd2, 16'hFFFF, 0, 0, 16'h0);
        op("R9 lpwr doze only", 1, 2'd2, 16'h0004, 0, 0, 16'h0);
        op("R10 unmapped write", 1, 2'd3, 16'hFFFF, 0, 0, 16'h0);
        op("R10 idle hold", 0, 2'd0, 16'h0, 0, 0, 16'h0);

        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            op("R3 R4 R5 R10 random", r[0], r[2:1], 16'($urandom),
               r[3], r[4], 16'($urandom));
        end

        rst = 1'b1;
        @(negedge clk);
        m_gate = '0; m_sleep = '0; m_lpwr = '0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 second reset enables", clk_enable, 16'hFFFF);
        read_all("R1 second reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule